// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit count of nanoseconds for precision time protocol work. The count has a hidden 32-bit fractional remainder below it. On every clock edge where the counter runs, it adds an increment held as a fixed-point number with 32 fractional bits. Ticks shorter than one nanosecond, such as 1.6 ns, therefore keep time with no long-term drift. The live time is driven on an output bus, where a timestamp capture block can sample it.

Software reaches the block through a simple strobe port with 32-bit words. A read of the low time word also latches the upper word, so the two reads form one coherent 64-bit value. Writes of the time and of the increment are staged on the low word and applied together when the high word is written. A link-speed strobe loads one of four preset increments. The slowest speed loads zero, which stops the clock.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time output, the active increment, the enable bit and the read data are all zero.
- R2: While the enable bit (bit 0 of the control word at address 0) is set, each clock edge adds the increment to the {nanoseconds, 32-bit fraction} accumulator. Nanoseconds carry out of the fraction. The first addition happens on the edge after the edge that writes the enable.
- R3: While the enable bit is clear, the time output holds its value.
- R4: A write to address 1 only stages the low time word, and the time output does not change. A write to address 2 loads {written word, staged word} into the count on that edge and clears the fraction. This load wins over a tick on the same edge.
- R5: A write to address 3 only stages the low increment word. A write to address 4 makes {written word, staged word} the active increment, where bits 31:0 are the fraction. Reads of addresses 3 and 4 return the low and high words of the active increment.
- R6: Read data is registered and valid on the cycle after the read strobe. A read of address 1 returns bits 31:0 of the count at the strobe edge and latches bits 63:32. A later read of address 2 returns that latched word, even if the count has since moved on.
- R7: The speed strobe loads a preset increment chosen by the 2-bit speed code. Code 0 (fastest link or no link) loads 0x1_99999999 (1.6 ns). Code 1 loads 0x3_33333333 (3.2 ns). Code 2 loads 0x20_00000000 (32 ns). Code 3 loads zero. A host write to address 4 on the same edge wins over the strobe.
- R8: The nanosecond count wraps modulo 2^64 with no special handling.
- R9: The time output always equals the live nanosecond count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| speed_load | input | 1 | Load the preset increment for the speed code |
| speed_code | input | 2 | Link speed code, 0 fastest, 3 slowest |
| time_o | output | 64 | Live nanosecond count |

## Verification
A time load, an increment commit and a preset load all take effect at the edge that carries the strobe. The bench samples the time output and the read data at the falling edge after that edge. A run enabled at edge E and disabled at edge D makes exactly D-E additions, one at each edge from E+1 to D. Every sweep point counts its edges this way and compares against the start time plus the product of the addition count and the increment, with the fraction dropped. Read data is compared one cycle after its strobe. The snapshot check pairs the read with the time output sampled just before the strobe edge.

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int TIME_W = 64,
  parameter int FRAC_W = 32,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3,
  parameter logic [63:0] INC_SPD0 = 64'h0000_0001_9999_9999,
  parameter logic [63:0] INC_SPD1 = 64'h0000_0003_3333_3333,
  parameter logic [63:0] INC_SPD2 = 64'h0000_0020_0000_0000,
  parameter logic [63:0] INC_SPD3 = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              speed_load,
  input  logic [1:0]        speed_code,
  output logic [TIME_W-1:0] time_o
);
  localparam int INC_W  = 2 * REG_W;
  localparam int ACC_W  = TIME_W + FRAC_W;
  localparam int THI_W  = TIME_W - REG_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TLO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_THI  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ILO  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IHI  = ADDR_W'(4);

  logic              en_q;
  logic [TIME_W-1:0] ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [INC_W-1:0]  inc_q;
  logic [REG_W-1:0]  tstage_q, istage_q;
  logic [THI_W-1:0]  snap_q;
  logic [ACC_W-1:0]  acc_next;
  logic [INC_W-1:0]  preset;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_tlo  = reg_wr && reg_addr == A_TLO;
  wire wr_thi  = reg_wr && reg_addr == A_THI;
  wire wr_ilo  = reg_wr && reg_addr == A_ILO;
  wire wr_ihi  = reg_wr && reg_addr == A_IHI;

  assign acc_next = {ns_q, frac_q} + ACC_W'(inc_q);
  assign time_o   = ns_q;

  always_comb begin
    case (speed_code)
      2'd0:    preset = INC_W'(INC_SPD0);
      2'd1:    preset = INC_W'(INC_SPD1);
      2'd2:    preset = INC_W'(INC_SPD2);
      default: preset = INC_W'(INC_SPD3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ns_q     <= '0;
      frac_q   <= '0;
      inc_q    <= '0;
      tstage_q <= '0;
      istage_q <= '0;
      snap_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[0];
      if (wr_tlo)  tstage_q <= reg_wdata;
      if (wr_ilo)  istage_q <= reg_wdata;

      if (wr_ihi)          inc_q <= {reg_wdata, istage_q};
      else if (speed_load) inc_q <= preset;

      if (wr_thi) begin
        ns_q   <= {THI_W'(reg_wdata), tstage_q};
        frac_q <= '0;
      end else if (en_q) begin
        {ns_q, frac_q} <= acc_next;
      end

      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= {{(REG_W-1){1'b0}}, en_q};
          A_TLO: begin
            reg_rdata <= ns_q[REG_W-1:0];
            snap_q    <= ns_q[TIME_W-1:REG_W];
          end
          A_THI:   reg_rdata <= REG_W'(snap_q);
          A_ILO:   reg_rdata <= inc_q[REG_W-1:0];
          A_IHI:   reg_rdata <= inc_q[INC_W-1:REG_W];
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk #(
  parameter int TIME_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              speed_load,
  input logic [1:0]        speed_code,
  input logic [TIME_W-1:0] time_o,
  input logic              en_q,
  input logic [2*REG_W-1:0] inc_q
);
  wire thi_wr = reg_wr && reg_addr == ADDR_W'(2);
  wire ihi_wr = reg_wr && reg_addr == ADDR_W'(4);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !thi_wr) |=> $stable(time_o)); // R3

  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    thi_wr |=> time_o[TIME_W-1:REG_W] == $past(reg_wdata)); // R4

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && reg_wr && reg_addr == ADDR_W'(1)) |=> $stable(time_o)); // R4

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !thi_wr) |=>
      (time_o == $past(time_o) + TIME_W'($past(inc_q[2*REG_W-1:REG_W]))) ||
      (time_o == $past(time_o) + TIME_W'($past(inc_q[2*REG_W-1:REG_W])) + TIME_W'(1))); // R2

  AST_SNAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(1)) |=> reg_rdata == $past(time_o[REG_W-1:0])); // R6

  AST_STOP_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_load && !ihi_wr && speed_code == 2'd3) |=> inc_q == '0); // R7

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_load && ihi_wr) |=> inc_q[2*REG_W-1:REG_W] == $past(reg_wdata)); // R7
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(.TIME_W(TIME_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .speed_load(speed_load),
  .speed_code(speed_code), .time_o(time_o), .en_q(en_q), .inc_q(inc_q)
);

// File: tb/test_ptp_tod_counter.sv
`timescale 1ns/1ps
module test_ptp_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        speed_load = 1'b0;
  logic [1:0]  speed_code = '0;
  logic [63:0] time_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ptp_tod_counter i_ptp_tod_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .speed_load(speed_load),
    .speed_code(speed_code), .time_o(time_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(3'd1, t[31:0]);
    wr(3'd2, t[63:32]);
  endtask

  task automatic set_inc(input logic [63:0] v);
    wr(3'd3, v[31:0]);
    wr(3'd4, v[63:32]);
  endtask

  task automatic speed(input logic [1:0] c);
    @(negedge clk); speed_load = 1'b1; speed_code = c;
    @(negedge clk); speed_load = 1'b0;
  endtask

  task automatic run_and_check(input string req, input logic [63:0] t0,
                               input logic [63:0] inc, input int k);
    logic [127:0] prod;
    logic [63:0] exp;
    set_time(t0);
    wr(3'd0, 32'd1);
    repeat (k) @(negedge clk);
    wr(3'd0, 32'd0);
    prod = 128'(k + 2) * 128'(inc);
    exp = t0 + prod[95:32];
    chk(req, time_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] cap;
    logic [63:0] incs [6];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", time_o, 64'h0);
    chk("R1 rdata", {32'h0, reg_rdata}, 64'h0);
    rd(3'd3, d); chk("R1 inc lo", {32'h0, d}, 64'h0);
    rd(3'd4, d); chk("R1 inc hi", {32'h0, d}, 64'h0);
    rd(3'd0, d); chk("R1 enable", {32'h0, d}, 64'h0);

    // R4 staging and load, R9 output
    wr(3'd1, 32'hDEAD_BEEF);
    chk("R4 low stage only", time_o, 64'h0);
    wr(3'd2, 32'h0000_00A5);
    chk("R4 R9 load", time_o, 64'h0000_00A5_DEAD_BEEF);

    // R3 disabled holds even with increment present
    set_inc(64'h0000_0001_0000_0000);
    repeat (10) @(negedge clk);
    chk("R3 hold", time_o, 64'h0000_00A5_DEAD_BEEF);
    rd(3'd0, d); chk("R3 enable off", {32'h0, d}, 64'h0);

    // R5 increment staging and readback
    wr(3'd3, 32'h1234_5678);
    rd(3'd3, d); chk("R5 lo staged not active", {32'h0, d}, 64'h0);
    wr(3'd4, 32'h0000_0009);
    rd(3'd3, d); chk("R5 lo active", {32'h0, d}, 64'h1234_5678);
    rd(3'd4, d); chk("R5 hi active", {32'h0, d}, 64'h9);

    // R7 presets
    speed(2'd0); rd(3'd3, d); chk("R7 code0 lo", {32'h0, d}, 64'h9999_9999);
    rd(3'd4, d); chk("R7 code0 hi", {32'h0, d}, 64'h1);
    speed(2'd1); rd(3'd3, d); chk("R7 code1 lo", {32'h0, d}, 64'h3333_3333);
    rd(3'd4, d); chk("R7 code1 hi", {32'h0, d}, 64'h3);
    speed(2'd2); rd(3'd3, d); chk("R7 code2 lo", {32'h0, d}, 64'h0);
    rd(3'd4, d); chk("R7 code2 hi", {32'h0, d}, 64'h20);
    speed(2'd3); rd(3'd4, d); chk("R7 code3 hi", {32'h0, d}, 64'h0);
    run_and_check("R7 stopped clock", 64'h0000_0000_0000_1000, 64'h0, 8);
    wr(3'd3, 32'h0);
    @(negedge clk);
    speed_load = 1'b1; speed_code = 2'd2;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h7;
    @(negedge clk);
    speed_load = 1'b0; reg_wr = 1'b0;
    rd(3'd4, d); chk("R7 host wins", {32'h0, d}, 64'h7);

    // R2 R4 R8 sweep over increments and run lengths
    incs[0] = 64'h0000_0001_9999_9999;
    incs[1] = 64'h0000_0003_3333_3333;
    incs[2] = 64'h0000_0020_0000_0000;
    incs[3] = 64'h0000_0000_8000_0000;
    incs[4] = 64'h0000_0000_0000_0001;
    incs[5] = 64'h0000_0000_5555_5555;
    for (int i = 0; i < 6; i++) begin
      if (i < 3) speed(2'(i)); else set_inc(incs[i]);
      for (int k = 0; k < 16; k++) begin
        run_and_check((k % 2) ? "R2 R4 sweep" : "R8 wrap sweep",
                      (k % 2) ? 64'h1234_5678_9ABC_DEF0 : 64'hFFFF_FFFF_FFFF_FF80,
                      incs[i], k);
      end
    end

    // R6 coherent snapshot across an upper-word carry
    set_inc(64'h0000_0010_0000_0000);
    set_time(64'h0000_0005_FFFF_FFC0);
    wr(3'd0, 32'd1);
    @(negedge clk);
    cap = time_o; reg_rd = 1'b1; reg_addr = 3'd1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R6 low word", {32'h0, reg_rdata}, {32'h0, cap[31:0]});
    repeat (6) @(negedge clk);
    rd(3'd2, d); chk("R6 latched high", {32'h0, d}, {32'h0, cap[63:32]});
    chk("R6 live high moved", {32'h0, time_o[63:32]}, 64'h6);
    wr(3'd0, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule